// File: doc/BRIEF.md
# Correlated Double Sampling Pixel Path with Reset-Level Statistics

This block sits after the column converters of an image sensor. Each cycle it may receive a pair of 8-bit samples: the reset (reference) level of a pixel and its exposed (signal) level. A two-bit selector chooses what reaches the output. The default choice is the signal minus the reference, which cancels the fixed pattern of each column. The other choices pass the reference alone or the signal alone. A per-color offset is then added. The color is picked from the parity of the row and the column in the Bayer mosaic. The result is registered and presented with a valid strobe.

In parallel, the block counts how many reference samples in a frame fall below a low limit and how many rise above a high limit. At each frame-start pulse it publishes one eighth of each raw count as a 16-bit read-only value. It then starts counting again for the new frame. An external loop can use these two figures to steer the converter's reset level.

Top module: `cds_pixel_path`

## Requirements
- R1: With `out_sel` = 2'b00 the pixel value is `smp_sig - smp_ref`; when `smp_sig` is not larger than `smp_ref` the value is 0.
- R2: With `out_sel` = 2'b01 the pixel value is `smp_ref`.
- R3: With `out_sel` = 2'b10 the pixel value is `smp_sig`.
- R4: The reserved encoding `out_sel` = 2'b11 produces exactly what 2'b00 produces.
- R5: The offset added to the pixel value is picked from the Bayer position:
  - `row_odd`=0, `col_odd`=0 selects `ofs_r`.
  - `row_odd`=0, `col_odd`=1 selects `ofs_g`.
  - `row_odd`=1, `col_odd`=0 selects `ofs_g`.
  - `row_odd`=1, `col_odd`=1 selects `ofs_b`.
- R6: When the pixel value plus the offset exceeds 255, the output is 255.
- R7: Timing of the output:
  - `pix_valid` rises one clock after a cycle with `smp_valid` high and is low otherwise.
  - `pix_data` changes only in the clock after an accepted sample and holds its value otherwise.
- R8: Every accepted sample with `smp_ref` < 3 adds one to the raw low count. At a frame start `low_count` becomes that raw count divided by eight, rounded down.
- R9: Every accepted sample with `smp_ref` > 123 adds one to the raw high count. At a frame start `high_count` becomes that raw count divided by eight, rounded down.
- R10: Frame boundaries:
  - `low_count` and `high_count` change only in the clock after `frame_start`.
  - The raw counts restart at each frame start.
  - A sample accepted in the same cycle as `frame_start` belongs to the new frame.
- R11: The raw counts saturate rather than wrap, so a published count never exceeds its all-ones value (0xFFFF at the default width).
- R12: While `rst_n` is low, `pix_valid`, `pix_data`, `low_count` and `high_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_ref | input | 8 | Reset (reference) level of the pixel |
| smp_sig | input | 8 | Exposed (signal) level of the pixel |
| row_odd | input | 1 | Pixel lies on an odd line |
| col_odd | input | 1 | Pixel lies in an odd column |
| frame_start | input | 1 | One-cycle pulse at the frame boundary |
| out_sel | input | 2 | Output type: 00 difference, 01 reference, 10 signal, 11 as 00 |
| ofs_r | input | 8 | Offset for red sites |
| ofs_g | input | 8 | Offset for green sites |
| ofs_b | input | 8 | Offset for blue sites |
| pix_valid | output | 1 | `pix_data` carries a new pixel |
| pix_data | output | 8 | Processed pixel value |
| low_count | output | 16 | Published low-reference count, divided by eight |
| high_count | output | 16 | Published high-reference count, divided by eight |

## Verification
The bench targets the clamps first:
- A signal at or below its reference must give 0. A wrapping subtractor would instead output values near 255.
- A large offset must stop at 255. An unclamped adder would drop the carry and output a small value.

The threshold edges come next. References of 2, 3, 123 and 124 separate a `<=`/`>=` slip from the intended strict comparisons. Counts of 17 and 25 expose a missing or misplaced divide-by-eight.

Two timing and overflow cases finish the list:
- A sample arriving in the same cycle as the frame pulse must land in the next frame, so an off-by-one restart changes the next published value.
- A narrow-count instance is driven past its limit. A wrapping accumulator would publish a small number instead of all ones.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [1:0] {
    SEL_DIFF = 2'b00,
    SEL_REF  = 2'b01,
    SEL_SIG  = 2'b10,
    SEL_RSVD = 2'b11
  } out_sel_e;

  typedef enum logic [1:0] {
    SITE_R = 2'b00,
    SITE_G = 2'b01,
    SITE_B = 2'b10
  } site_e;

endpackage

// File: rtl/cds_select.sv
module cds_select
  import cds_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ref_lvl,
  input  logic [DATA_W-1:0] sig_lvl,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] base
);

  logic [DATA_W-1:0] diff;

  always_comb begin
    if (sig_lvl > ref_lvl) diff = sig_lvl - ref_lvl;
    else                   diff = '0;
  end

  always_comb begin
    unique case (out_sel_e'(sel))
      SEL_REF: base = ref_lvl;
      SEL_SIG: base = sig_lvl;
      default: base = diff;
    endcase
  end

endmodule

// File: rtl/bayer_offset.sv
module bayer_offset
  import cds_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              row_odd,
  input  logic              col_odd,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] ofs_r,
  input  logic [DATA_W-1:0] ofs_g,
  input  logic [DATA_W-1:0] ofs_b,
  output logic [DATA_W-1:0] result
);

  site_e             site;
  logic [DATA_W-1:0] ofs;
  logic [DATA_W:0]   sum;

  always_comb begin
    if (row_odd == col_odd) site = row_odd ? SITE_B : SITE_R;
    else                    site = SITE_G;
  end

  always_comb begin
    unique case (site)
      SITE_R:  ofs = ofs_r;
      SITE_B:  ofs = ofs_b;
      default: ofs = ofs_g;
    endcase
  end

  always_comb begin
    sum    = {1'b0, base} + {1'b0, ofs};
    result = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
  end

endmodule

// File: rtl/level_counter.sv
module level_counter #(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 16,
  parameter int SHIFT   = 3,
  parameter int LIMIT   = 3,
  parameter bit ABOVE   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  ref_lvl,
  input  logic               frame_start,
  output logic [COUNT_W-1:0] published
);

  localparam int ACC_W = COUNT_W + SHIFT;
  localparam logic [DATA_W-1:0] LIM_V = DATA_W'(LIMIT);
  localparam logic [ACC_W-1:0]  ACC_MAX = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0]  ACC_ONE = ACC_W'(1);

  logic               in_range;
  logic               hit;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [COUNT_W-1:0] pub_d;

  generate
    if (ABOVE) begin : g_above
      assign in_range = (ref_lvl > LIM_V);
    end else begin : g_below
      assign in_range = (ref_lvl < LIM_V);
    end
  endgenerate

  assign hit = smp_valid && in_range;

  always_comb begin
    acc_d = acc_q;
    pub_d = published;
    if (frame_start) begin
      pub_d = acc_q[ACC_W-1:SHIFT];
      acc_d = hit ? ACC_ONE : '0;
    end else if (hit && (acc_q != ACC_MAX)) begin
      acc_d = acc_q + ACC_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      published <= '0;
    end else begin
      acc_q     <= acc_d;
      published <= pub_d;
    end
  end

endmodule

// File: rtl/cds_pixel_path.sv
module cds_pixel_path
  import cds_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int COUNT_W    = 16,
  parameter int STAT_SHIFT = 3,
  parameter int LOW_LIMIT  = 3,
  parameter int HIGH_LIMIT = 123
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_ref,
  input  logic [DATA_W-1:0]  smp_sig,
  input  logic               row_odd,
  input  logic               col_odd,
  input  logic               frame_start,
  input  logic [1:0]         out_sel,
  input  logic [DATA_W-1:0]  ofs_r,
  input  logic [DATA_W-1:0]  ofs_g,
  input  logic [DATA_W-1:0]  ofs_b,
  output logic               pix_valid,
  output logic [DATA_W-1:0]  pix_data,
  output logic [COUNT_W-1:0] low_count,
  output logic [COUNT_W-1:0] high_count
);

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] pix_d;

  cds_select #(.DATA_W(DATA_W)) u_select (
    .ref_lvl (smp_ref),
    .sig_lvl (smp_sig),
    .sel     (out_sel),
    .base    (base)
  );

  bayer_offset #(.DATA_W(DATA_W)) u_offset (
    .row_odd (row_odd),
    .col_odd (col_odd),
    .base    (base),
    .ofs_r   (ofs_r),
    .ofs_g   (ofs_g),
    .ofs_b   (ofs_b),
    .result  (pix_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      pix_valid <= smp_valid;
      if (smp_valid) pix_data <= pix_d;
    end
  end

  level_counter #(
    .DATA_W (DATA_W), .COUNT_W (COUNT_W), .SHIFT (STAT_SHIFT),
    .LIMIT  (LOW_LIMIT), .ABOVE (1'b0)
  ) u_low (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .ref_lvl     (smp_ref),
    .frame_start (frame_start),
    .published   (low_count)
  );

  level_counter #(
    .DATA_W (DATA_W), .COUNT_W (COUNT_W), .SHIFT (STAT_SHIFT),
    .LIMIT  (HIGH_LIMIT), .ABOVE (1'b1)
  ) u_high (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .ref_lvl     (smp_ref),
    .frame_start (frame_start),
    .published   (high_count)
  );

endmodule

// File: rtl/cds_pixel_path_chk.sv
module cds_pixel_path_chk
  import cds_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_valid,
  input logic [DATA_W-1:0]  smp_ref,
  input logic [DATA_W-1:0]  smp_sig,
  input logic               frame_start,
  input logic [1:0]         out_sel,
  input logic [DATA_W-1:0]  ofs_r,
  input logic [DATA_W-1:0]  ofs_g,
  input logic [DATA_W-1:0]  ofs_b,
  input logic               pix_valid,
  input logic [DATA_W-1:0]  pix_data,
  input logic [COUNT_W-1:0] low_count,
  input logic [COUNT_W-1:0] high_count
);

  logic no_ofs;
  assign no_ofs = (ofs_r == '0) && (ofs_g == '0) && (ofs_b == '0);

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pix_valid == $past(smp_valid)));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(pix_data));

  p_counts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(low_count) && $stable(high_count)));

  p_neg_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_sel == 2'b00 && smp_sig <= smp_ref && no_ofs)
      |=> (pix_data == '0));

  p_ref_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_sel == 2'b01 && no_ofs) |=> (pix_data == $past(smp_ref)));

  p_sig_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_sel == 2'b10 && no_ofs) |=> (pix_data == $past(smp_sig)));

  p_top_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_sel == 2'b10 && smp_sig == {DATA_W{1'b1}})
      |=> (pix_data == {DATA_W{1'b1}}));

endmodule

bind cds_pixel_path cds_pixel_path_chk #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ref     (smp_ref),
  .smp_sig     (smp_sig),
  .frame_start (frame_start),
  .out_sel     (out_sel),
  .ofs_r       (ofs_r),
  .ofs_g       (ofs_g),
  .ofs_b       (ofs_b),
  .pix_valid   (pix_valid),
  .pix_data    (pix_data),
  .low_count   (low_count),
  .high_count  (high_count)
);

// File: tb/tb_cds_pixel_path.sv
`timescale 1ns/1ps
module tb_cds_pixel_path;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [7:0]  smp_ref, smp_sig;
  logic        row_odd, col_odd;
  logic        frame_start;
  logic [1:0]  out_sel;
  logic [7:0]  ofs_r, ofs_g, ofs_b;
  logic        pix_valid;
  logic [7:0]  pix_data;
  logic [15:0] low_count, high_count;
  logic        sat_valid;
  logic [7:0]  sat_data;
  logic [3:0]  sat_low, sat_high;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cds_pixel_path dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ref(smp_ref),
    .smp_sig(smp_sig), .row_odd(row_odd), .col_odd(col_odd),
    .frame_start(frame_start), .out_sel(out_sel), .ofs_r(ofs_r),
    .ofs_g(ofs_g), .ofs_b(ofs_b), .pix_valid(pix_valid),
    .pix_data(pix_data), .low_count(low_count), .high_count(high_count)
  );

  // Narrow-count copy used only to reach saturation within the run (R11)
  cds_pixel_path #(.COUNT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ref(smp_ref),
    .smp_sig(smp_sig), .row_odd(row_odd), .col_odd(col_odd),
    .frame_start(frame_start), .out_sel(out_sel), .ofs_r(ofs_r),
    .ofs_g(ofs_g), .ofs_b(ofs_b), .pix_valid(sat_valid),
    .pix_data(sat_data), .low_count(sat_low), .high_count(sat_high)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int r, input int s, input int sel,
                               input bit ro, input bit co);
    int b, o, t;
    if (sel == 1)      b = r;
    else if (sel == 2) b = s;
    else               b = (s > r) ? s - r : 0;
    if (!ro && !co)    o = ofs_r;
    else if (ro && co) o = ofs_b;
    else               o = ofs_g;
    t = b + o;
    return (t > 255) ? 255 : t;
  endfunction

  task automatic push(input logic [7:0] r, input logic [7:0] s,
                      input bit ro, input bit co);
    @(negedge clk);
    smp_ref = r; smp_sig = s; row_odd = ro; col_odd = co; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic burst(input logic [7:0] r, input int n);
    for (int i = 0; i < n; i++) push(r, 8'd0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R12 pix_valid", pix_valid, 0);
    check("R12 pix_data", pix_data, 0);
    check("R12 low_count", low_count, 0);
    check("R12 high_count", high_count, 0);
  endtask

  task automatic t_modes();
    ofs_r = 0; ofs_g = 0; ofs_b = 0;
    out_sel = 2'b00; push(8'd40, 8'd200, 0, 0);
    check("R1 diff", pix_data, 160);
    push(8'd90, 8'd90, 0, 0);
    check("R1 equal clamps 0", pix_data, 0);
    push(8'd100, 8'd20, 0, 0);
    check("R1 negative clamps 0", pix_data, 0);
    out_sel = 2'b01; push(8'd77, 8'd5, 1, 0);
    check("R2 ref only", pix_data, 77);
    out_sel = 2'b10; push(8'd77, 8'd5, 1, 1);
    check("R3 sig only", pix_data, 5);
    out_sel = 2'b11; push(8'd30, 8'd130, 0, 1);
    check("R4 reserved as diff", pix_data, 100);
    push(8'd130, 8'd30, 0, 1);
    check("R4 reserved negative clamps", pix_data, 0);
    out_sel = 2'b00;
  endtask

  task automatic t_bayer();
    ofs_r = 8'd1; ofs_g = 8'd20; ofs_b = 8'd60;
    out_sel = 2'b10;
    for (int k = 0; k < 4; k++) begin
      push(8'd0, 8'd100, k[1], k[0]);
      check("R5 site offset", pix_data, model(0, 100, 2, k[1], k[0]));
    end
    out_sel = 2'b00;
    push(8'd10, 8'd50, 1, 1);
    check("R5 diff plus blue", pix_data, 100);
  endtask

  task automatic t_clamp();
    ofs_r = 8'd200; ofs_g = 8'd0; ofs_b = 8'd255;
    out_sel = 2'b10;
    push(8'd0, 8'd100, 0, 0);
    check("R6 sum clamps 255", pix_data, 255);
    push(8'd0, 8'd1, 1, 1);
    check("R6 256 clamps 255", pix_data, 255);
    push(8'd0, 8'd55, 0, 0);
    check("R6 exactly 255", pix_data, 255);
    push(8'd0, 8'd54, 0, 0);
    check("R6 below limit", pix_data, 254);
    ofs_r = 0; ofs_b = 0; out_sel = 2'b00;
  endtask

  task automatic t_timing();
    out_sel = 2'b10;
    @(negedge clk);
    smp_ref = 0; smp_sig = 8'd33; row_odd = 0; col_odd = 0; smp_valid = 1'b1;
    check("R7 no early valid", pix_valid, 0);
    @(negedge clk);
    smp_valid = 1'b0; smp_sig = 8'd99;
    check("R7 valid after one clock", pix_valid, 1);
    check("R7 data after one clock", pix_data, 33);
    @(negedge clk);
    check("R7 valid drops", pix_valid, 0);
    @(negedge clk);
    check("R7 data held", pix_data, 33);
    out_sel = 2'b00;
  endtask

  task automatic t_low();
    pulse_frame();
    burst(8'd2, 10); burst(8'd0, 7);
    burst(8'd3, 5); burst(8'd123, 3);
    pulse_frame();
    check("R8 low count 17/8", low_count, 2);
    check("R8 no high from 3..123", high_count, 0);
  endtask

  task automatic t_high();
    pulse_frame();
    burst(8'd124, 16); burst(8'd255, 9); burst(8'd123, 10);
    pulse_frame();
    check("R9 high count 25/8", high_count, 3);
    check("R9 low stays 0", low_count, 0);
  endtask

  task automatic t_frame();
    pulse_frame();
    burst(8'd1, 8);
    check("R10 hold before pulse", low_count, 0);
    @(negedge clk);
    frame_start = 1'b1; smp_valid = 1'b1; smp_ref = 8'd0;
    @(negedge clk);
    frame_start = 1'b0; smp_valid = 1'b0;
    check("R10 publish excludes same-cycle", low_count, 1);
    burst(8'd0, 7);
    check("R10 held mid frame", low_count, 1);
    pulse_frame();
    check("R10 same-cycle sample in new frame", low_count, 1);
    pulse_frame();
    check("R10 restart empties", low_count, 0);
  endtask

  task automatic t_sat();
    pulse_frame();
    burst(8'd0, 200);
    pulse_frame();
    check("R11 wide count 200/8", low_count, 25);
    check("R11 narrow count saturates", sat_low, 15);
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 0; smp_ref = 0; smp_sig = 0;
    row_odd = 0; col_odd = 0; frame_start = 0; out_sel = 2'b00;
    ofs_r = 0; ofs_g = 0; ofs_b = 0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_modes();
    t_bayer();
    t_clamp();
    t_timing();
    t_low();
    t_high();
    t_frame();
    t_sat();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule